// File: doc/BRIEF.md
# Write-Once Register File with Readiness Scoreboard

This block is a register file for a dataflow-style core. Every register has a full/empty flag, and the flag alone decides whether a value is usable. Inside one procedure frame a register accepts one write. After that it keeps its value until a frame-clear command empties it. An issuing unit presents two register indices. For each it gets the value and a ready flag that is high exactly when that register is full. No hazard comparison against in-flight writes is needed.

A small multiply unit sits beside the storage. It can be loaded with two source indices before either operand exists, and it watches the two flags itself. As soon as one source is full and holds zero, it finishes with a zero result without waiting for the other source. Otherwise it waits until both sources are full and then takes a fixed number of cycles. Results leave through a valid/ready handshake. A frame-clear command takes a mask of registers and empties all of them in one cycle, so the registers of a finished frame can be written again.

Top module: `wo_scoreboard_rf`

## Requirements
- R1: After reset every register is empty, `full_mask` is 0, `wr_err` is low, `mul_ld_ready` is high and `mul_res_valid` is low.
- R2: A write to an empty register, with no clear in the same cycle, sets that register's bit in `full_mask` (bit i belongs to register i) and stores the data. The value can be read from the next cycle on.
- R3: A write to a full register, with no clear in the same cycle, is rejected. The stored value stays unchanged, and `wr_err` is high for exactly the one cycle after the rejected write.
- R4: Each read port's ready flag equals the full bit of the indexed register. Read data is the stored value when that register is full and zero when it is empty.
- R5: A clear with mask M empties every register i with M[i]=1 on the next edge and leaves all other registers and their values untouched.
- R6: When a clear and a write happen in the same cycle, the write is dropped entirely, even if its target is outside the mask, and `wr_err` stays low.
- R7: A register emptied by a clear accepts a new write, which stores the new value.
- R8: The multiply unit accepts a load only when `mul_ld_ready` is high. If neither source holds a known zero, the unit completes only after both sources are full. `mul_res_valid` rises on the fourth edge after the first edge at which the loaded unit finds both sources full, and `mul_res_data` is then the low 32 bits of the product.
- R9: If either loaded source is full and holds zero, the unit finishes on the next edge with result zero, whether or not the other source is full.
- R10: A multiply may be loaded while a source is empty. It waits and then starts on its own when the missing source is written, with the timing of R8 counted from that write.
- R11: While `mul_res_valid` is high and `mul_res_ready` is low, the result and its valid flag hold steady, and `mul_ld_ready` stays low. After a handshake the unit is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | First read port index |
| rd_a_data | output | 32 | First read port data, zero when empty |
| rd_a_rdy | output | 1 | First read port ready flag |
| rd_b_idx | input | 4 | Second read port index |
| rd_b_data | output | 32 | Second read port data, zero when empty |
| rd_b_rdy | output | 1 | Second read port ready flag |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write target register |
| wr_data | input | 32 | Write data |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| clr_en | input | 1 | Frame-clear request |
| clr_mask | input | 16 | Registers to empty |
| full_mask | output | 16 | Full flag of every register |
| mul_ld_valid | input | 1 | Multiply load request |
| mul_ld_ready | output | 1 | Multiply unit idle and able to load |
| mul_src_a | input | 4 | Multiply first source index |
| mul_src_b | input | 4 | Multiply second source index |
| mul_res_valid | output | 1 | Multiply result valid |
| mul_res_ready | input | 1 | Multiply result accepted |
| mul_res_data | output | 32 | Multiply result |

## Verification
The bench builds the block with its default parameters: sixteen 32-bit registers and a four-cycle multiply. Sixteen registers are few enough that random writes often hit a full register, so rejections, clears and rewrites interleave densely. The four-cycle latency lets the bench count every idle cycle of the multiply unit exactly. Early-zero completion with either source empty, a deferred start after a late write, and a stalled result handshake are driven as directed cases.

// File: rtl/wofrf_pkg.sv
package wofrf_pkg;

    localparam int NREG_DEF    = 16;
    localparam int XLEN_DEF    = 32;
    localparam int MUL_LAT_DEF = 4;

    typedef enum logic [1:0] {
        MU_IDLE,
        MU_WAIT,
        MU_BUSY,
        MU_DONE
    } mu_state_e;

    // readiness status of one multiply source
    typedef struct packed {
        logic ready;
        logic zero;
    } opnd_stat_t;

    function automatic opnd_stat_t make_stat(input logic rdy, input logic is_zero);
        opnd_stat_t s;
        s.ready = rdy;
        s.zero  = rdy & is_zero;
        return s;
    endfunction

endpackage

// File: rtl/wofrf_store.sv
module wofrf_store #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_idx,
    input  logic [XLEN-1:0]            wr_data,
    input  logic                       clr_en,
    input  logic [NREG-1:0]            clr_mask,
    output logic [NREG-1:0]            full_q,
    output logic [NREG-1:0][XLEN-1:0]  store_q,
    output logic                       wr_err
);

    logic hit_full;
    logic err_q;

    assign hit_full = full_q[wr_idx];
    assign wr_err   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q  <= '0;
            store_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= wr_en & ~clr_en & hit_full;
            if (clr_en) begin
                full_q <= full_q & ~clr_mask;
            end else if (wr_en && !hit_full) begin
                full_q[wr_idx]  <= 1'b1;
                store_q[wr_idx] <= wr_data;
            end
        end
    end

    // R3
    reject_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr_en && full_q[wr_idx]) |=>
            (wr_err && store_q[$past(wr_idx)] == $past(store_q[wr_idx])));

    // R5
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((full_q & $past(clr_mask)) == '0));

    // R6
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && wr_en && !full_q[wr_idx] && !clr_mask[wr_idx]) |=>
            (!full_q[$past(wr_idx)] && !wr_err));

    // R2
    write_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr_en && !full_q[wr_idx]) |=>
            (full_q[$past(wr_idx)] && store_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/wofrf_rdsel.sv
module wofrf_rdsel #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic [NREG-1:0]            full_q,
    input  logic [NREG-1:0][XLEN-1:0]  store_q,
    input  logic [AW-1:0]              idx,
    output logic [XLEN-1:0]            data,
    output logic                       rdy
);

    always_comb begin
        rdy  = full_q[idx];
        data = full_q[idx] ? store_q[idx] : '0;
    end

endmodule

// File: rtl/wofrf_mul.sv
module wofrf_mul
    import wofrf_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int XLEN    = 32,
    parameter int MUL_LAT = 4,
    localparam int AW     = $clog2(NREG),
    localparam int CW     = $clog2(MUL_LAT + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_valid,
    output logic            ld_ready,
    input  logic [AW-1:0]   ld_src_a,
    input  logic [AW-1:0]   ld_src_b,
    output logic [AW-1:0]   src_a_q,
    output logic [AW-1:0]   src_b_q,
    input  logic [XLEN-1:0] opa_data,
    input  logic            opa_rdy,
    input  logic [XLEN-1:0] opb_data,
    input  logic            opb_rdy,
    output logic            res_valid,
    input  logic            res_ready,
    output logic [XLEN-1:0] res_data
);

    mu_state_e       state_q;
    logic [CW-1:0]   cnt_q;
    logic [XLEN-1:0] res_q;
    logic [XLEN-1:0] prod;
    opnd_stat_t      st_a, st_b;

    assign st_a = make_stat(opa_rdy, opa_data == '0);
    assign st_b = make_stat(opb_rdy, opb_data == '0);
    assign prod = opa_data * opb_data;

    assign ld_ready  = (state_q == MU_IDLE);
    assign res_valid = (state_q == MU_DONE);
    assign res_data  = res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MU_IDLE;
            cnt_q   <= '0;
            res_q   <= '0;
            src_a_q <= '0;
            src_b_q <= '0;
        end else begin
            unique case (state_q)
                MU_IDLE: begin
                    if (ld_valid) begin
                        src_a_q <= ld_src_a;
                        src_b_q <= ld_src_b;
                        state_q <= MU_WAIT;
                    end
                end
                MU_WAIT: begin
                    if (st_a.zero || st_b.zero) begin
                        res_q   <= '0;
                        state_q <= MU_DONE;
                    end else if (st_a.ready && st_b.ready) begin
                        res_q   <= prod;
                        cnt_q   <= CW'(MUL_LAT);
                        state_q <= MU_BUSY;
                    end
                end
                MU_BUSY: begin
                    if (cnt_q == CW'(1)) state_q <= MU_DONE;
                    else                 cnt_q   <= cnt_q - CW'(1);
                end
                MU_DONE: begin
                    if (res_ready) state_q <= MU_IDLE;
                end
                default: state_q <= MU_IDLE;
            endcase
        end
    end

    // R9
    early_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == MU_WAIT && (st_a.zero || st_b.zero)) |=>
            (res_valid && res_data == '0));

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == MU_WAIT && !st_a.zero && !st_b.zero && !(st_a.ready && st_b.ready))
            |=> !res_valid);

    // R11
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && !ld_ready));

endmodule

// File: rtl/wo_scoreboard_rf.sv
module wo_scoreboard_rf
    import wofrf_pkg::*;
#(
    parameter int NREG    = NREG_DEF,
    parameter int XLEN    = XLEN_DEF,
    parameter int MUL_LAT = MUL_LAT_DEF,
    localparam int AW     = $clog2(NREG),
    localparam int NPORT  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    output logic            rd_a_rdy,
    input  logic [AW-1:0]   rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    output logic            rd_b_rdy,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    output logic            wr_err,
    input  logic            clr_en,
    input  logic [NREG-1:0] clr_mask,
    output logic [NREG-1:0] full_mask,
    input  logic            mul_ld_valid,
    output logic            mul_ld_ready,
    input  logic [AW-1:0]   mul_src_a,
    input  logic [AW-1:0]   mul_src_b,
    output logic            mul_res_valid,
    input  logic            mul_res_ready,
    output logic [XLEN-1:0] mul_res_data
);

    logic [NREG-1:0]           full_q;
    logic [NREG-1:0][XLEN-1:0] store_q;
    logic [AW-1:0]             rp_idx  [NPORT];
    logic [XLEN-1:0]           rp_data [NPORT];
    logic                      rp_rdy  [NPORT];
    logic [AW-1:0]             m_src_a, m_src_b;

    wofrf_store #(.NREG(NREG), .XLEN(XLEN)) store_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .clr_en   (clr_en),
        .clr_mask (clr_mask),
        .full_q   (full_q),
        .store_q  (store_q),
        .wr_err   (wr_err)
    );

    assign rp_idx[0] = rd_a_idx;
    assign rp_idx[1] = rd_b_idx;
    assign rp_idx[2] = m_src_a;
    assign rp_idx[3] = m_src_b;

    for (genvar g = 0; g < NPORT; g++) begin : g_rp
        wofrf_rdsel #(.NREG(NREG), .XLEN(XLEN)) rdsel_i (
            .full_q  (full_q),
            .store_q (store_q),
            .idx     (rp_idx[g]),
            .data    (rp_data[g]),
            .rdy     (rp_rdy[g])
        );
    end

    assign rd_a_data = rp_data[0];
    assign rd_a_rdy  = rp_rdy[0];
    assign rd_b_data = rp_data[1];
    assign rd_b_rdy  = rp_rdy[1];
    assign full_mask = full_q;

    wofrf_mul #(.NREG(NREG), .XLEN(XLEN), .MUL_LAT(MUL_LAT)) mul_i (
        .clk       (clk),
        .rst       (rst),
        .ld_valid  (mul_ld_valid),
        .ld_ready  (mul_ld_ready),
        .ld_src_a  (mul_src_a),
        .ld_src_b  (mul_src_b),
        .src_a_q   (m_src_a),
        .src_b_q   (m_src_b),
        .opa_data  (rp_data[2]),
        .opa_rdy   (rp_rdy[2]),
        .opb_data  (rp_data[3]),
        .opb_rdy   (rp_rdy[3]),
        .res_valid (mul_res_valid),
        .res_ready (mul_res_ready),
        .res_data  (mul_res_data)
    );

    // R4
    rdy_match_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_rdy == full_mask[rd_a_idx]) && (rd_b_rdy == full_mask[rd_b_idx]));

    // R4
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!full_mask[rd_a_idx] |-> rd_a_data == '0));

endmodule

// File: tb/wo_scoreboard_rf_tb_top.sv
module wo_scoreboard_rf_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, mul_src_a, mul_src_b;
    logic [31:0] rd_a_data, rd_b_data, wr_data, mul_res_data;
    logic        rd_a_rdy, rd_b_rdy, wr_en, wr_err, clr_en;
    logic [15:0] clr_mask, full_mask;
    logic        mul_ld_valid, mul_ld_ready, mul_res_valid, mul_res_ready;

    int total = 0;
    int bad   = 0;

    bit          m_full [16];
    logic [31:0] m_val  [16];

    always #5 clk = ~clk;

    wo_scoreboard_rf dut_i (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_rdy(rd_a_rdy),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_rdy(rd_b_rdy),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err),
        .clr_en(clr_en), .clr_mask(clr_mask), .full_mask(full_mask),
        .mul_ld_valid(mul_ld_valid), .mul_ld_ready(mul_ld_ready),
        .mul_src_a(mul_src_a), .mul_src_b(mul_src_b),
        .mul_res_valid(mul_res_valid), .mul_res_ready(mul_res_ready),
        .mul_res_data(mul_res_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int i);
        return m_full[i] ? m_val[i] : 32'h0;
    endfunction

    function automatic logic [15:0] exp_mask();
        logic [15:0] m;
        for (int i = 0; i < 16; i++) m[i] = m_full[i];
        return m;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_in();
        wr_en = 0; clr_en = 0; clr_mask = '0; mul_ld_valid = 0;
    endtask

    task automatic do_write(input int i, input logic [31:0] d);
        wr_en = 1; wr_idx = 4'(i); wr_data = d;
        step();
        wr_en = 0;
        if (!m_full[i]) begin m_full[i] = 1; m_val[i] = d; end
    endtask

    task automatic clear_all();
        clr_en = 1; clr_mask = 16'hffff;
        step();
        clr_en = 0; clr_mask = '0;
        for (int i = 0; i < 16; i++) m_full[i] = 0;
    endtask

    task automatic load_mul(input int a, input int b);
        mul_src_a = 4'(a); mul_src_b = 4'(b); mul_ld_valid = 1;
        step();
        mul_ld_valid = 0;
    endtask

    task automatic take_result(input logic [31:0] exp, input string req);
        chk(mul_res_valid === 1'b1, req, 32'(mul_res_valid), 32'd1);
        chk(mul_res_data === exp, req, mul_res_data, exp);
        mul_res_ready = 1;
        step();
        mul_res_ready = 0;
        chk(mul_res_valid === 1'b0 && mul_ld_ready === 1'b1, "R11", 32'(mul_ld_ready), 32'd1);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; idle_in(); mul_res_ready = 0;
        rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
        mul_src_a = 0; mul_src_b = 0;
        for (int i = 0; i < 16; i++) begin m_full[i] = 0; m_val[i] = 0; end
        step(); step();
        rst = 0;
        step();

        // R1 reset state
        chk(full_mask === 16'h0, "R1", 32'(full_mask), 32'h0);
        chk(wr_err === 1'b0, "R1", 32'(wr_err), 32'h0);
        chk(mul_ld_ready === 1'b1 && mul_res_valid === 1'b0, "R1", 32'(mul_res_valid), 32'h0);

        // R2 write empty register
        do_write(0, 32'h5);
        rd_a_idx = 0; #1;
        chk(rd_a_rdy === 1'b1 && rd_a_data === 32'h5, "R2", rd_a_data, 32'h5);
        chk(full_mask === 16'h0001, "R2", 32'(full_mask), 32'h1);

        // R3 rewrite is rejected, one-cycle error
        do_write(0, 32'h9);
        chk(wr_err === 1'b1, "R3", 32'(wr_err), 32'h1);
        chk(rd_a_data === 32'h5, "R3", rd_a_data, 32'h5);
        step();
        chk(wr_err === 1'b0, "R3", 32'(wr_err), 32'h0);

        // R4 empty register reads zero, not ready
        rd_b_idx = 4'd9; #1;
        chk(rd_b_rdy === 1'b0 && rd_b_data === 32'h0, "R4", rd_b_data, 32'h0);

        // R5 clear keeps unmasked registers
        do_write(3, 32'hab);
        clr_en = 1; clr_mask = 16'h0001;
        step();
        idle_in(); m_full[0] = 0;
        chk(full_mask === 16'h0008, "R5", 32'(full_mask), 32'h8);
        rd_b_idx = 3; #1;
        chk(rd_b_data === 32'hab, "R5", rd_b_data, 32'hab);

        // R6 clear wins over a write outside its mask
        clr_en = 1; clr_mask = 16'h0008; wr_en = 1; wr_idx = 7; wr_data = 32'h77;
        step();
        idle_in(); m_full[3] = 0;
        chk(full_mask === 16'h0000, "R6", 32'(full_mask), 32'h0);
        chk(wr_err === 1'b0, "R6", 32'(wr_err), 32'h0);

        // R7 rewrite after clear
        do_write(0, 32'h11);
        rd_a_idx = 0; #1;
        chk(rd_a_data === 32'h11 && wr_err === 1'b0, "R7", rd_a_data, 32'h11);

        // R8 both operands ready before load
        clear_all();
        do_write(1, 32'd6);
        do_write(2, 32'd7);
        load_mul(1, 2);
        chk(mul_res_valid === 1'b0 && mul_ld_ready === 1'b0, "R8", 32'(mul_res_valid), 32'h0);
        for (int k = 0; k < 4; k++) begin
            step();
            chk(mul_res_valid === 1'b0, "R8", 32'(mul_res_valid), 32'h0);
        end
        step();
        // R11 stall holds the result
        step();
        chk(mul_res_valid === 1'b1 && mul_res_data === 32'd42, "R11", mul_res_data, 32'd42);
        take_result(32'd42, "R8");

        // R9 early zero, first operand zero, second empty
        clear_all();
        do_write(3, 32'h0);
        load_mul(3, 4);
        chk(mul_res_valid === 1'b0, "R9", 32'(mul_res_valid), 32'h0);
        step();
        take_result(32'h0, "R9");

        // R9 early zero, second operand zero, first empty
        load_mul(5, 3);
        step();
        take_result(32'h0, "R9");

        // R10 deferred start after late write
        clear_all();
        do_write(5, 32'd3);
        load_mul(5, 6);
        for (int k = 0; k < 3; k++) begin
            step();
            chk(mul_res_valid === 1'b0, "R10", 32'(mul_res_valid), 32'h0);
        end
        do_write(6, 32'd9);
        chk(mul_res_valid === 1'b0, "R10", 32'(mul_res_valid), 32'h0);
        for (int k = 0; k < 4; k++) begin
            step();
            chk(mul_res_valid === 1'b0, "R10", 32'(mul_res_valid), 32'h0);
        end
        step();
        take_result(32'd27, "R10");

        // constrained random register traffic
        begin
            bit exp_err = 0;
            for (int it = 0; it < 400; it++) begin
                int ra = $urandom % 16;
                int rb = $urandom % 16;
                bit w  = ($urandom % 3) != 0;
                int wi = $urandom % 16;
                logic [31:0] wd = $urandom;
                bit c  = ($urandom % 16) == 0;
                logic [15:0] cm = 16'($urandom);
                chk(wr_err === exp_err, "R3", 32'(wr_err), 32'(exp_err));
                chk(full_mask === exp_mask(), "R5", 32'(full_mask), 32'(exp_mask()));
                rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
                wr_en = w; wr_idx = 4'(wi); wr_data = wd;
                clr_en = c; clr_mask = cm;
                #1;
                chk(rd_a_rdy === m_full[ra] && rd_a_data === exp_rd(ra), "R4", rd_a_data, exp_rd(ra));
                chk(rd_b_rdy === m_full[rb] && rd_b_data === exp_rd(rb), "R2", rd_b_data, exp_rd(rb));
                exp_err = 0;
                if (c) begin
                    for (int i = 0; i < 16; i++) if (cm[i]) m_full[i] = 0;
                end else if (w) begin
                    if (m_full[wi]) exp_err = 1;
                    else begin m_full[wi] = 1; m_val[wi] = wd; end
                end
                step();
            end
            idle_in();
            chk(wr_err === exp_err, "R3", 32'(wr_err), 32'(exp_err));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule